// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block is the control core of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It tracks each in-flight instruction as a small token: a valid bit, register-write and memory-write controls, and a cause code. Each stage reports its own fault on an input pin. The controller writes the cause into the faulting instruction's token, turns every younger instruction into a bubble, and stops fetching. Older instructions drain and complete as normal. A fault is acted on only when its instruction reaches writeback. At that point the controller saves the cause and a resume address, flushes the pipeline, and redirects fetch to a fixed handler address.

An external interrupt request is also accepted. The controller picks the next clean instruction that completes writeback as the last one, lets it commit, and discards everything younger. The resume address points at the first discarded instruction. The datapath, ALU and memories are outside the block; they appear only as the fault pins and the per-instruction write controls.

Control is a three-state machine:
- `ST_RUN` is normal flow.
- `ST_DRAIN` means a fault is recorded and fetch is halted.
- `ST_IRQ_WAIT` means an interrupt is pending.

The transitions are as follows:
- `ST_RUN` moves to `ST_DRAIN` when a fault is recorded.
- `ST_RUN` moves to `ST_IRQ_WAIT` when a request is seen with no fault.
- `ST_IRQ_WAIT` moves to `ST_DRAIN` when a fault is recorded before the interrupt is taken.
- `ST_DRAIN` and `ST_IRQ_WAIT` return to `ST_RUN` on the cycle a trap is taken.

Top module: `precise_exc_ctl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `fetch_pc` equals `RESET_PC`, `fetch_en` is 1, and `trap_take`, `irq_ack`, `reg_we` and `mem_we` are 0. Also `trap_cause` and `trap_epc` are 0.
- R2: A fault recorded in a stage tags that instruction with a fixed code: fetch = 1, decode = 2, execute = 3, memory = 4. Interrupts use code 5. On a trap, the code is presented on `trap_cause` from the next cycle.
- R3: Every instruction younger than a newly recorded fault becomes a bubble in that same cycle. A bubble never commits and can never record a fault.
- R4: `fetch_en` is 0 from the cycle after a fault is recorded through the cycle its trap is taken. While it is low, `fetch_pc` holds its value.
- R5: Instructions older than the faulting one commit their register writes, one per cycle, before the trap.
- R6: `trap_take` pulses in the cycle a tagged instruction is in writeback. That instruction does not write its register, and `trap_epc` holds its own address from the next cycle.
- R7: When several instructions carry faults, the oldest one is trapped. This holds even when a younger instruction faulted in an earlier cycle.
- R8: An instruction whose memory access faults performs no memory write. Instructions older than it still perform theirs.
- R9: An interrupt request seen in `ST_RUN` is taken on the next cycle whose writeback instruction is valid and untagged. That instruction commits, `irq_ack` and `trap_take` pulse together, no memory write occurs that cycle, and `trap_epc` becomes the committed address plus 4.
- R10: A fault recorded in the same cycle as a request, or before the request is taken, wins. The request is not acknowledged and the trap carries the fault's code.
- R11: In the cycle after `trap_take`, `fetch_pc` equals `HANDLER_PC` and `fetch_en` is 1. Fetch then steps by 4 per cycle. No instruction reaches writeback for the next three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_rwe | input | 1 | Register-write control of the instruction fetched this cycle |
| if_mwe | input | 1 | Memory-write control of the instruction fetched this cycle |
| if_fault | input | 1 | Fetch access fault for the instruction fetched this cycle |
| id_fault | input | 1 | Illegal opcode found in decode |
| ex_fault | input | 1 | Arithmetic fault in execute |
| mem_fault | input | 1 | Load/store access fault in the memory stage |
| irq_req | input | 1 | External interrupt request, level, held until acknowledged |
| fetch_en | output | 1 | Fetch happens this cycle |
| fetch_pc | output | PC_W | Address being fetched |
| mem_we | output | 1 | Memory-stage instruction commits its store |
| mem_pc | output | PC_W | Address of the memory-stage instruction |
| reg_we | output | 1 | Writeback instruction commits its register write |
| wb_pc | output | PC_W | Address of the writeback instruction |
| trap_take | output | 1 | Trap taken this cycle; the pipeline is flushed |
| irq_ack | output | 1 | The trap this cycle serves the interrupt |
| trap_cause | output | 3 | Saved cause code |
| trap_epc | output | PC_W | Saved resume address |

## Verification
The bench builds the controller with `PC_W` = 16, `RESET_PC` = 0 and `HANDLER_PC` = 0x0200. With these values, every expected address is a small multiple of 4 counted from reset, and the handler address stands well clear of the program addresses.

Each table row places one or two fault or interrupt events at chosen cycles. The rows are chosen to exercise specific orderings:
- A younger fault that is overtaken by an older one.
- Two faults in the same cycle.
- A squashed slot that is told to fault.
- An interrupt that arrives while the pipeline is still empty.
- An interrupt that loses to a fault.

For each row, the bench checks the cycle of the trap, the saved state, the commit counts, the fetch-halt length and the restart at the handler.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    localparam int EXC_W     = 3;
    localparam int NUM_STAGE = 4;   // stages that can raise a fault: fetch, decode, execute, memory

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE    = 3'd0,
        EXC_FETCH   = 3'd1,
        EXC_ILLEGAL = 3'd2,
        EXC_ARITH   = 3'd3,
        EXC_DATA    = 3'd4,
        EXC_IRQ     = 3'd5
    } exc_e;

    typedef struct packed {
        logic valid;
        logic rwe;
        logic mwe;
        exc_e code;
    } tok_t;

    localparam tok_t TOK_BUBBLE = '{valid: 1'b0, rwe: 1'b0, mwe: 1'b0, code: EXC_NONE};

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_DRAIN    = 2'd1,
        ST_IRQ_WAIT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/pxc_latch.sv
module pxc_latch
    import pxc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  tok_t            d_tok,
    input  logic [PC_W-1:0] d_pc,
    output tok_t            q_tok,
    output logic [PC_W-1:0] q_pc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_tok <= TOK_BUBBLE;
            q_pc  <= '0;
        end else begin
            q_tok <= flush ? TOK_BUBBLE : d_tok;
            q_pc  <= d_pc;
        end
    end

endmodule

// File: rtl/pxc_fault_net.sv
module pxc_fault_net
    import pxc_pkg::*;
#(
    parameter int NST = NUM_STAGE
) (
    input  tok_t           view_tok [NST],
    input  logic [NST-1:0] fault,
    output tok_t           post_tok [NST],
    output logic           any_hit
);

    logic [NST-1:0] hit;
    logic [NST-1:0] shadow;   // an older stage recorded a fault this cycle

    always_comb begin
        shadow = '0;
        for (int i = NST - 2; i >= 0; i--) begin
            shadow[i] = shadow[i+1] | hit[i+1];
        end
    end

    for (genvar g = 0; g < NST; g++) begin : g_stage
        assign hit[g] = view_tok[g].valid && (view_tok[g].code == EXC_NONE) && fault[g];

        always_comb begin
            post_tok[g] = view_tok[g];
            if (shadow[g]) begin
                post_tok[g] = TOK_BUBBLE;
            end else if (hit[g]) begin
                post_tok[g].code = exc_e'(EXC_W'(g + 1));
            end
        end
    end

    assign any_hit = |hit;

endmodule

// File: rtl/pxc_ctl_fsm.sv
module pxc_ctl_fsm
    import pxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic new_fault,
    input  logic take_fault,
    input  logic wb_clean,
    output logic fetch_allow,
    output logic take_irq
);

    ctl_state_e state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (take_fault)     state <= ST_RUN;
                    else if (new_fault) state <= ST_DRAIN;
                    else if (irq_req)   state <= ST_IRQ_WAIT;
                end
                ST_DRAIN: begin
                    if (take_fault)     state <= ST_RUN;
                end
                ST_IRQ_WAIT: begin
                    if (take_fault || take_irq) state <= ST_RUN;
                    else if (new_fault)         state <= ST_DRAIN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        fetch_allow = 1'b1;
        take_irq    = 1'b0;
        unique case (state)
            ST_RUN:      fetch_allow = 1'b1;
            ST_DRAIN:    fetch_allow = 1'b0;
            ST_IRQ_WAIT: take_irq    = wb_clean && !take_fault;
            default:     fetch_allow = 1'b1;
        endcase
    end

endmodule

// File: rtl/precise_exc_ctl.sv
module precise_exc_ctl
    import pxc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] RESET_PC   = '0,
    parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(32'h0000_0100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_rwe,
    input  logic            if_mwe,
    input  logic            if_fault,
    input  logic            id_fault,
    input  logic            ex_fault,
    input  logic            mem_fault,
    input  logic            irq_req,
    output logic            fetch_en,
    output logic [PC_W-1:0] fetch_pc,
    output logic            mem_we,
    output logic [PC_W-1:0] mem_pc,
    output logic            reg_we,
    output logic [PC_W-1:0] wb_pc,
    output logic            trap_take,
    output logic            irq_ack,
    output logic [EXC_W-1:0] trap_cause,
    output logic [PC_W-1:0] trap_epc
);

    localparam int NST     = NUM_STAGE;
    localparam int WB_IDX  = NST - 1;
    localparam int MEM_IDX = NST - 2;
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    tok_t            view_tok [NST];
    logic [PC_W-1:0] view_pc  [NST];
    tok_t            post_tok [NST];
    tok_t            lat_tok  [NST];
    logic [PC_W-1:0] lat_pc   [NST];
    logic [NST-1:0]  fault_vec;
    logic            new_fault;
    logic            take_fault;
    logic            take_irq;
    logic            wb_clean;
    logic            fetch_allow;
    logic [PC_W-1:0] pc_q;
    tok_t            wb_tok;
    tok_t            mem_tok;

    assign fault_vec  = {mem_fault, ex_fault, id_fault, if_fault};
    assign wb_tok     = lat_tok[WB_IDX];
    assign mem_tok    = lat_tok[MEM_IDX];
    assign take_fault = wb_tok.valid && (wb_tok.code != EXC_NONE);
    assign wb_clean   = wb_tok.valid && (wb_tok.code == EXC_NONE);
    assign trap_take  = take_fault || take_irq;
    assign irq_ack    = take_irq;
    assign fetch_en   = fetch_allow && !trap_take;
    assign fetch_pc   = pc_q;

    always_comb begin
        view_tok[0] = '{valid: fetch_en, rwe: if_rwe, mwe: if_mwe, code: EXC_NONE};
        view_pc[0]  = pc_q;
        for (int i = 1; i < NST; i++) begin
            view_tok[i] = lat_tok[i-1];
            view_pc[i]  = lat_pc[i-1];
        end
    end

    pxc_fault_net #(.NST(NST)) u_fnet (
        .view_tok (view_tok),
        .fault    (fault_vec),
        .post_tok (post_tok),
        .any_hit  (new_fault)
    );

    for (genvar g = 0; g < NST; g++) begin : g_latch
        pxc_latch #(.PC_W(PC_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (trap_take),
            .d_tok (post_tok[g]),
            .d_pc  (view_pc[g]),
            .q_tok (lat_tok[g]),
            .q_pc  (lat_pc[g])
        );
    end

    pxc_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .new_fault   (new_fault),
        .take_fault  (take_fault),
        .wb_clean    (wb_clean),
        .fetch_allow (fetch_allow),
        .take_irq    (take_irq)
    );

    // commit strobes: a store commits in the memory stage, a register write in writeback
    assign mem_we = mem_tok.valid && mem_tok.mwe && (mem_tok.code == EXC_NONE)
                    && !mem_fault && !trap_take;
    assign mem_pc = lat_pc[MEM_IDX];
    assign reg_we = wb_clean && wb_tok.rwe;
    assign wb_pc  = lat_pc[WB_IDX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= RESET_PC;
            trap_cause <= '0;
            trap_epc   <= '0;
        end else begin
            if (trap_take) begin
                pc_q       <= HANDLER_PC;
                trap_cause <= take_fault ? wb_tok.code : EXC_IRQ;
                trap_epc   <= take_fault ? lat_pc[WB_IDX] : lat_pc[WB_IDX] + PC_STEP;
            end else if (fetch_en) begin
                pc_q <= pc_q + PC_STEP;
            end
        end
    end

endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_en,
    input logic [PC_W-1:0] fetch_pc,
    input logic            trap_take,
    input logic            irq_ack,
    input logic            reg_we,
    input logic            mem_we,
    input logic [PC_W-1:0] wb_pc,
    input logic [2:0]      trap_cause,
    input logic [PC_W-1:0] trap_epc
);

    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (fetch_pc == HANDLER_PC) && fetch_en);                     // R11

    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !trap_take);                                               // R11

    AST_FAULT_NO_WB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && !irq_ack) |-> !reg_we);                                    // R6

    AST_FAULT_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && !irq_ack) |=> (trap_epc == $past(wb_pc)));                 // R6

    AST_ACK_WITH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> trap_take);                                                  // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (trap_cause == 3'd5) && (trap_epc == $past(wb_pc) + PC_W'(4))); // R9

    AST_NO_STORE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> !mem_we);                                                  // R9

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !trap_take) |=> $stable(fetch_pc));                        // R4

endmodule

bind precise_exc_ctl pxc_checker #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (.*);

// File: tb/tb_precise_exc_ctl.sv
module tb_precise_exc_ctl;

    localparam int              CLK_PERIOD = 10;
    localparam int              PC_W       = 16;
    localparam logic [PC_W-1:0] HANDLER    = 16'h0200;
    localparam int              NVEC       = 11;

    // s: 0 fetch, 1 decode, 2 execute, 3 memory fault, 4 interrupt, 7 none
    typedef struct packed {
        logic [2:0]  s1;
        logic [7:0]  t1;
        logic [2:0]  s2;
        logic [7:0]  t2;
        logic [7:0]  tk;
        logic [2:0]  cause;
        logic [15:0] epc;
        logic [3:0]  halt;
        logic        ack;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 8'd3, 3'd7, 8'd0,  8'd7, 3'd1, 16'd12, 4'd4, 1'b0},
        '{3'd1, 8'd5, 3'd7, 8'd0,  8'd8, 3'd2, 16'd16, 4'd3, 1'b0},
        '{3'd2, 8'd6, 3'd7, 8'd0,  8'd8, 3'd3, 16'd16, 4'd2, 1'b0},
        '{3'd3, 8'd9, 3'd7, 8'd0, 8'd10, 3'd4, 16'd24, 4'd1, 1'b0},
        '{3'd1, 8'd4, 3'd7, 8'd0,  8'd7, 3'd2, 16'd12, 4'd3, 1'b0},
        '{3'd1, 8'd5, 3'd3, 8'd6,  8'd7, 3'd4, 16'd12, 4'd2, 1'b0},
        '{3'd2, 8'd6, 3'd0, 8'd6,  8'd8, 3'd3, 16'd16, 4'd2, 1'b0},
        '{3'd2, 8'd5, 3'd1, 8'd6,  8'd7, 3'd3, 16'd12, 4'd2, 1'b0},
        '{3'd4, 8'd5, 3'd7, 8'd0,  8'd6, 3'd5, 16'd12, 4'd1, 1'b1},
        '{3'd4, 8'd1, 3'd7, 8'd0,  8'd4, 3'd5, 16'd4,  4'd1, 1'b1},
        '{3'd3, 8'd5, 3'd4, 8'd5,  8'd6, 3'd4, 16'd8,  4'd1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            if_rwe, if_mwe, if_fault, id_fault, ex_fault, mem_fault, irq_req;
    logic            fetch_en, mem_we, reg_we, trap_take, irq_ack;
    logic [PC_W-1:0] fetch_pc, mem_pc, wb_pc, trap_epc;
    logic [2:0]      trap_cause;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    precise_exc_ctl #(.PC_W(PC_W), .RESET_PC('0), .HANDLER_PC(HANDLER)) dut (
        .clk(clk), .rst_n(rst_n), .if_rwe(if_rwe), .if_mwe(if_mwe),
        .if_fault(if_fault), .id_fault(id_fault), .ex_fault(ex_fault),
        .mem_fault(mem_fault), .irq_req(irq_req), .fetch_en(fetch_en),
        .fetch_pc(fetch_pc), .mem_we(mem_we), .mem_pc(mem_pc), .reg_we(reg_we),
        .wb_pc(wb_pc), .trap_take(trap_take), .irq_ack(irq_ack),
        .trap_cause(trap_cause), .trap_epc(trap_epc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        if_fault = 0; id_fault = 0; ex_fault = 0; mem_fault = 0; irq_req = 0;
    endtask

    task automatic apply_reset();
        rst_n = 0; if_rwe = 1; if_mwe = 1;
        clear_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1;   // cycle 0 starts here
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int    regs, mems, halts, tk;
        logic  ack, taken;
        string ctag;
        regs = 0; mems = 0; halts = 0; tk = -1; ack = 0; taken = 0;
        apply_reset();
        for (int cyc = 0; cyc < 40 && !taken; cyc++) begin
            if_fault  = (v.s1 == 0 && cyc == v.t1) || (v.s2 == 0 && cyc == v.t2);
            id_fault  = (v.s1 == 1 && cyc == v.t1) || (v.s2 == 1 && cyc == v.t2);
            ex_fault  = (v.s1 == 2 && cyc == v.t1) || (v.s2 == 2 && cyc == v.t2);
            mem_fault = (v.s1 == 3 && cyc == v.t1) || (v.s2 == 3 && cyc == v.t2);
            irq_req   = (v.s1 == 4 && cyc >= v.t1) || (v.s2 == 4 && cyc >= v.t2);
            #1;
            if (idx == 0 && cyc == 0) begin
                check("R1 fetch_pc", 32'(fetch_pc), 32'd0);
                check("R1 fetch_en", 32'(fetch_en), 32'd1);
                check("R1 trap_take", 32'(trap_take), 32'd0);
                check("R1 commits", 32'({reg_we, mem_we, irq_ack}), 32'd0);
                check("R1 saved", 32'({trap_cause, trap_epc}), 32'd0);
            end
            regs += int'(reg_we);
            mems += int'(mem_we);
            if (!fetch_en) halts++;
            if (trap_take) begin taken = 1; tk = cyc; ack = irq_ack; end
            @(negedge clk);
        end
        clear_inputs();
        if (idx >= 5 && idx <= 7)  ctag = "R7 cause";
        else if (idx == 10)        ctag = "R10 cause";
        else if (v.ack)            ctag = "R9 cause";
        else                       ctag = "R2 cause";
        #1;   // cycle tk+1
        check(v.ack ? "R9 trap cycle" : "R6 trap cycle", 32'(tk), 32'(v.tk));
        check(ctag, 32'(trap_cause), 32'(v.cause));
        check(v.ack ? "R9 epc" : "R6 epc", 32'(trap_epc), 32'(v.epc));
        check("R5 reg commits", 32'(regs), 32'(v.epc >> 2));
        check("R3 R8 mem commits", 32'(mems), 32'(v.epc >> 2));
        check("R4 fetch halt cycles", 32'(halts), 32'(v.halt));
        check(idx == 10 ? "R10 ack" : "R9 ack", 32'(ack), 32'(v.ack));
        check("R11 handler fetch", 32'({fetch_en, fetch_pc}), 32'({1'b1, HANDLER}));
        @(negedge clk); #1;
        check("R11 fetch step", 32'(fetch_pc), 32'(HANDLER + 16'd4));
        repeat (2) @(negedge clk);
        #1;   // cycle tk+4
        check("R11 empty wb", 32'(reg_we), 32'd0);
        @(negedge clk); #1;
        check("R11 handler commit", 32'({reg_we, wb_pc}), 32'({1'b1, HANDLER}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);

        // directed: reset in the middle of a drain returns to the reset state
        apply_reset();
        @(negedge clk);
        id_fault = 1;                      // cycle 1: decode fault on the first instruction
        @(negedge clk);
        id_fault = 0; #1;                  // cycle 2: fetch halted
        check("R4 halt after fault", 32'(fetch_en), 32'd0);
        rst_n = 0; #1;
        check("R1 reset fetch_pc", 32'(fetch_pc), 32'd0);
        check("R1 reset fetch_en", 32'(fetch_en), 32'd1);
        check("R1 reset trap", 32'({trap_take, reg_we, mem_we}), 32'd0);
        rst_n = 1;

        // directed: interrupt with no instruction stream keeps waiting
        apply_reset();
        if_rwe = 0; if_mwe = 0;
        irq_req = 1;
        repeat (3) @(negedge clk);
        #1;                                // cycle 3: writeback still empty
        check("R9 wait for writeback", 32'({trap_take, irq_ack}), 32'd0);
        @(negedge clk); #1;                // cycle 4: first instruction in writeback
        check("R9 ack on first clean wb", 32'({trap_take, irq_ack, reg_we}), 32'b110);
        clear_inputs();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule